// File: doc/BRIEF.md
# Coherence Inbox with Selective Overtaking

This block is the incoming message queue on the memory or directory side of a cache-coherent system. Each message it holds carries a command code, the id of the source cache and a line address. Entries are kept in age order, with slot 0 holding the oldest. The protocol engine marks an entry it cannot service yet by raising the stall bit for that entry's slot.

A stalled message does not hold up unrelated traffic. The dequeue port offers the oldest entry that meets two conditions: it is not stalled, and it may legally overtake every older entry still waiting. An entry may overtake an older one only when both of these hold:

- at least one of the two messages is a cache request;
- the two messages differ in source or in address.

When an entry is taken from the middle of the queue, the younger entries close the gap, so slot numbers always give age rank.

Top module: `coh_inbox`

## Requirements
- R1: After reset the queue is empty: `deq_valid` is 0, `full` is 0 and `enq_ready` is 1.
- R2: Messages are stored in arrival order. When slot 0 is occupied and not stalled, it is the entry offered (`deq_slot` = 0).
- R3: With DEPTH (8) entries held, `full` is 1 and `enq_ready` is 0. An enqueue attempted while full is refused and stores nothing.
- R4: An entry whose stall bit is set is never offered. A younger unstalled entry that may pass is offered in its place.
- R5: An entry may pass an older one only if at least one of the two has command code 0 (cache request). Two messages with non-zero codes never pass each other.
- R6: An entry may pass an older one only if the two differ in source id or in address. Messages with equal source and equal address keep their arrival order.
- R7: The offered entry is the oldest one that is unstalled and allowed to pass every older entry still waiting. If no entry qualifies, `deq_valid` is 0.
- R8: When an entry is removed from the middle, the younger entries move down one slot each and keep their relative order.
- R9: An entry is removed exactly when `deq_valid` and `deq_ready` are both 1. `deq_cmd`, `deq_src` and `deq_addr` give the offered entry's fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_cmd | input | CMD_W | Command of the incoming message (0 = cache request) |
| enq_src | input | SRC_W | Source cache id |
| enq_addr | input | ADDR_W | Line address |
| enq_ready | output | 1 | Queue can take a message this cycle |
| full | output | 1 | All DEPTH slots are occupied |
| stall | input | DEPTH | Per-slot stall from the protocol engine, bit i for age slot i |
| deq_valid | output | 1 | An eligible entry is offered |
| deq_slot | output | SLOT_W | Age slot of the offered entry |
| deq_cmd | output | CMD_W | Command of the offered entry |
| deq_src | output | SRC_W | Source of the offered entry |
| deq_addr | output | ADDR_W | Address of the offered entry |
| deq_ready | input | 1 | Consumer takes the offered entry |

## Verification
The assertions assume that the engine's stall bits refer to current age slots. Bits for unoccupied slots are treated as don't-care. The assertions also assume `deq_ready` has effect only while `deq_valid` is high. The stimulus changes stall only between clock edges, after it has observed the slot layout. Enqueue and dequeue are not both driven in the same cycle, so every slot position the bench predicts follows from one operation at a time.

// File: rtl/coh_inbox.sv
module coh_inbox #(
  parameter int DEPTH  = 8,
  parameter int CMD_W  = 2,
  parameter int SRC_W  = 3,
  parameter int ADDR_W = 8,
  parameter logic [CMD_W-1:0] REQ_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [CMD_W-1:0]  enq_cmd,
  input  logic [SRC_W-1:0]  enq_src,
  input  logic [ADDR_W-1:0] enq_addr,
  output logic              enq_ready,
  output logic              full,
  input  logic [DEPTH-1:0]  stall,
  output logic              deq_valid,
  output logic [$clog2(DEPTH)-1:0] deq_slot,
  output logic [CMD_W-1:0]  deq_cmd,
  output logic [SRC_W-1:0]  deq_src,
  output logic [ADDR_W-1:0] deq_addr,
  input  logic              deq_ready
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [CMD_W-1:0]  q_cmd  [DEPTH];
  logic [SRC_W-1:0]  q_src  [DEPTH];
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  elig;
  logic [SLOT_W-1:0] sel;
  logic              enq_fire, deq_fire;
  logic [CNT_W-1:0]  wr_pos;

  assign full      = (count == CNT_W'(DEPTH));
  assign enq_ready = !full;
  assign enq_fire  = enq_valid && enq_ready;
  assign deq_fire  = deq_valid && deq_ready;
  assign wr_pos    = count - CNT_W'(deq_fire);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = (i < int'(count)) && !stall[i];
      for (int j = 0; j < DEPTH; j++)
        if (j < i && !(((q_cmd[i] == REQ_CODE) || (q_cmd[j] == REQ_CODE)) &&
                       ((q_src[i] != q_src[j]) || (q_addr[i] != q_addr[j]))))
          elig[i] = 1'b0;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (elig[i]) sel = SLOT_W'(i);
  end

  assign deq_valid = |elig;
  assign deq_slot  = sel;
  assign deq_cmd   = q_cmd[sel];
  assign deq_src   = q_src[sel];
  assign deq_addr  = q_addr[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(enq_fire) - CNT_W'(deq_fire);
      for (int k = 0; k < DEPTH; k++)
        if (deq_fire && k >= int'(sel) && k + 1 < DEPTH) begin
          q_cmd[k]  <= q_cmd[k+1];
          q_src[k]  <= q_src[k+1];
          q_addr[k] <= q_addr[k+1];
        end
      if (enq_fire) begin
        q_cmd[wr_pos[SLOT_W-1:0]]  <= enq_cmd;
        q_src[wr_pos[SLOT_W-1:0]]  <= enq_src;
        q_addr[wr_pos[SLOT_W-1:0]] <= enq_addr;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R3
  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    full && enq_valid && !deq_ready |=> full); // R3
  AST_NEVER_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> !stall[deq_slot]); // R4
  AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) && !stall[0] |-> deq_valid && deq_slot == '0); // R2
  AST_PASS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && deq_slot != '0 |-> (q_cmd[0] == REQ_CODE) || (deq_cmd == REQ_CODE)); // R5
  AST_PASS_NEEDS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && deq_slot != '0 |-> (q_src[0] != deq_src) || (q_addr[0] != deq_addr)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    deq_fire && !enq_fire |=> count == $past(count) - 1'b1); // R9
endmodule

// File: tb/coh_inbox_tb_top.sv
`timescale 1ns/1ps
module coh_inbox_tb_top;
  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, deq_ready = 0;
  logic [1:0] enq_cmd = 0;
  logic [2:0] enq_src = 0;
  logic [7:0] enq_addr = 0;
  logic [7:0] stall = 0;
  logic enq_ready, full, deq_valid;
  logic [2:0] deq_slot;
  logic [1:0] deq_cmd;
  logic [2:0] deq_src;
  logic [7:0] deq_addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  coh_inbox dut_i (.clk, .rst_n, .enq_valid, .enq_cmd, .enq_src, .enq_addr,
    .enq_ready, .full, .stall, .deq_valid, .deq_slot, .deq_cmd, .deq_src,
    .deq_addr, .deq_ready);

  // {cmd0,src0,addr0, cmd1,src1,addr1, stall0, stall1, exp_valid, exp_slot}
  localparam logic [31:0] VEC [8] = '{
    {2'd0,3'd1,8'h10, 2'd1,3'd2,8'h20, 1'b1,1'b0, 1'b1,3'd1}, // R4 R6 diff src
    {2'd0,3'd1,8'h10, 2'd1,3'd1,8'h10, 1'b1,1'b0, 1'b0,3'd0}, // R6 same src+addr
    {2'd1,3'd1,8'h10, 2'd2,3'd2,8'h20, 1'b1,1'b0, 1'b0,3'd0}, // R5 no request
    {2'd1,3'd1,8'h10, 2'd0,3'd1,8'h11, 1'b1,1'b0, 1'b1,3'd1}, // R5 R6 younger req
    {2'd0,3'd3,8'h30, 2'd0,3'd4,8'h30, 1'b0,1'b0, 1'b1,3'd0}, // R2 head first
    {2'd0,3'd1,8'h10, 2'd0,3'd2,8'h10, 1'b1,1'b1, 1'b0,3'd0}, // R4 both stalled
    {2'd0,3'd1,8'h10, 2'd0,3'd1,8'h10, 1'b1,1'b0, 1'b0,3'd0}, // R6 two same reqs
    {2'd0,3'd5,8'h40, 2'd1,3'd5,8'h41, 1'b1,1'b0, 1'b1,3'd1}  // R6 same src diff addr
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; stall = 0; enq_valid = 0; deq_ready = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic push(logic [1:0] c, logic [2:0] s, logic [7:0] a);
    @(negedge clk); enq_valid = 1; enq_cmd = c; enq_src = s; enq_addr = a;
    @(negedge clk); enq_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk); deq_ready = 1;
    @(negedge clk); deq_ready = 0;
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R1 deq_valid", deq_valid, 0);
    check("R1 full", full, 0);
    check("R1 enq_ready", enq_ready, 1);

    for (int v = 0; v < 8; v++) begin
      do_reset();
      push(VEC[v][31:30], VEC[v][29:27], VEC[v][26:19]);
      push(VEC[v][18:17], VEC[v][16:14], VEC[v][13:6]);
      stall = {6'd0, VEC[v][4], VEC[v][5]};
      #1;
      check("R7 table valid", deq_valid, VEC[v][3]);
      if (VEC[v][3]) begin
        check("R7 table slot", deq_slot, VEC[v][2:0]);
        check("R9 table addr", deq_addr, VEC[v][2:0] == 0 ? VEC[v][26:19] : VEC[v][13:6]);
      end
    end

    do_reset();
    for (int i = 0; i < 8; i++) push(2'd1, 3'(i), 8'(8'h50 + i));
    #1;
    check("R3 full", full, 1);
    check("R3 enq_ready", enq_ready, 0);
    push(2'd1, 3'd7, 8'hEE);
    for (int i = 0; i < 8; i++) begin
      #1;
      check("R2 order", deq_addr, 8'h50 + i);
      check("R9 slot0", deq_slot, 0);
      pop();
    end
    #1;
    check("R3 refused entry absent", deq_valid, 0);

    do_reset();
    push(2'd0, 3'd1, 8'h10);
    push(2'd1, 3'd2, 8'h20);
    push(2'd1, 3'd3, 8'h30);
    stall = 8'b0000_0001;
    #1;
    check("R4 bypass slot", deq_slot, 1);
    check("R9 bypass src", deq_src, 2);
    pop();
    #1;
    check("R8 compact slot", deq_slot, 1);
    check("R8 compact addr", deq_addr, 8'h30);
    stall = 0;
    #1;
    check("R2 head after unstall", deq_addr, 8'h10);
    check("R9 head cmd", deq_cmd, 0);

    do_reset();
    push(2'd0, 3'd1, 8'h10);
    push(2'd1, 3'd2, 8'h20);
    push(2'd1, 3'd2, 8'h20);
    stall = 8'b0000_0011;
    #1;
    check("R7 must pass every older", deq_valid, 0);
    stall = 8'b0000_0001;
    #1;
    check("R7 oldest eligible", deq_slot, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule